// File: doc/BRIEF.md
# Multicycle Register-File Processor Core

This block is a small sequential processor that runs one instruction at a time, stepping through fetch, decode and execute phases whose cycle costs are fixed. It holds four general data registers, a program counter, an instruction latch, and a pair of memory-side holding registers: one for the address and one for the data word. It talks to a single-port synchronous memory through an address bus, a write-data bus, a read-data bus, an access-request strobe and a write strobe.

Instructions are 16 bits wide. Operands come either from two registers or from one register and one memory word. The supported operations are copy, add, subtract, multiply (keeping the low half of the product), load, store and halt. Every internal transfer takes one cycle. Every memory access keeps the bus stable for ten cycles. Decode takes two cycles, add and subtract two, and multiply five. As a result, the latency of every instruction is known exactly, and software timing can be computed ahead of time.

Top module: `mc_cpu`

## Requirements
- R1: While reset is held and right after it, `halted`, `mem_req` and `mem_we` are low, the program counter is 0, and all four data registers read as zero.
- R2: An instruction word is opcode[15:12], first register[11:10], second register[9:8] and memory address[7:0]. The opcodes are 0 halt, 1 copy reg←reg, 2 load reg←mem, 3 store mem←reg, 4 add reg,reg, 5 add reg,mem, 6 sub reg,reg, 7 sub reg,mem and 8 multiply reg,reg. Fetch reads the word at the program counter in 12 cycles and advances the counter by 2.
- R3: Decode takes 2 cycles. The end-to-end latency is 15 cycles for a register copy, 16 for a register add or subtract, and 19 for a multiply.
- R4: The end-to-end latency is 26 cycles for a load, 27 for an add or subtract with a memory operand, and 25 for a store.
- R5: Add and subtract wrap modulo 2^16, and multiply keeps the low 16 bits of the product.
- R6: The result of every two-operand operation, copy and load is written to the first register field. The second register field, or the memory word, is the other operand. For subtraction the other operand is the one subtracted.
- R7: A store keeps `mem_we` and `mem_req` high for exactly 10 consecutive cycles. During that window `mem_addr` holds the instruction's address field and `mem_wdata` holds the first register's value, and both stay stable.
- R8: Halt raises `halted` 14 cycles after the halt instruction begins. `halted` then stays high until reset, and no further memory access takes place.
- R9: Every memory access holds `mem_req` high for exactly 10 cycles with an even, stable `mem_addr`, where address bit 0 is forced to 0. Read data is captured on the last cycle of the window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 8 | Byte address of the current memory access |
| mem_wdata | output | 16 | Data word driven during a store |
| mem_rdata | input | 16 | Word returned by memory at `mem_addr` |
| mem_req | output | 1 | High for each cycle of a memory access window |
| mem_we | output | 1 | High during a store window |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
The hardest condition to reach from the ports is a wrong cycle count inside the execute phase of one instruction. The only outputs the core exposes are the memory strobes and the halt flag, so a single latency error can hide inside a long program. The bench runs a fixed program that mixes every opcode and places stores at known points. It checks the cycle on which each store window opens against a running sum of the per-instruction latencies, so each block of instructions between stores is timed on its own. It also sweeps operand pairs that include 0, 1, the sign boundary and all-ones, so that wrap-around and low-half multiply results appear in the stored words.

// File: rtl/mc_cpu_pkg.sv
package mc_cpu_pkg;

  // Fixed micro-step costs in clock cycles
  localparam int CYC_XFER = 1;
  localparam int CYC_MEM  = 10;
  localparam int CYC_DEC  = 2;
  localparam int CYC_ADD  = 2;
  localparam int CYC_MUL  = 5;
  localparam int CNT_W    = $clog2(CYC_MEM + 1);

  typedef enum logic [3:0] {
    OP_HALT   = 4'd0,
    OP_MOV_RR = 4'd1,
    OP_LOAD   = 4'd2,
    OP_STORE  = 4'd3,
    OP_ADD_RR = 4'd4,
    OP_ADD_RM = 4'd5,
    OP_SUB_RR = 4'd6,
    OP_SUB_RM = 4'd7,
    OP_MUL_RR = 4'd8
  } opcode_e;

  typedef enum logic [3:0] {
    S_FADDR,   // address register <- program counter
    S_FMEM,    // instruction fetch window
    S_FIR,     // instruction latch <- data register
    S_DEC,     // decode
    S_XADDR,   // operand address set-up
    S_XMEM,    // operand read or store window
    S_XREG,    // single-cycle register write
    S_XALU,    // arithmetic step
    S_HALT
  } state_e;

  typedef enum logic [1:0] {
    FN_ADD,
    FN_SUB,
    FN_MUL
  } alu_fn_e;

endpackage

// File: rtl/mc_cpu_regfile.sv
module mc_cpu_regfile #(
  parameter int DW   = 16,
  parameter int NREG = 4,
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [RW-1:0] wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic [RW-1:0] rd_sel_a,
  input  logic [RW-1:0] rd_sel_b,
  output logic [DW-1:0] rd_data_a,
  output logic [DW-1:0] rd_data_b
);

  logic [DW-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic en_g;
    assign en_g = wr_en && (wr_sel == RW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[g] <= '0;
      end else if (en_g) begin
        regs_q[g] <= wr_data;
      end
    end
  end

  assign rd_data_a = regs_q[rd_sel_a];
  assign rd_data_b = regs_q[rd_sel_b];

endmodule

// File: rtl/mc_cpu_alu.sv
module mc_cpu_alu
  import mc_cpu_pkg::*;
#(
  parameter int DW = 16
) (
  input  alu_fn_e       fn,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  output logic [DW-1:0] res
);

  always_comb begin
    unique case (fn)
      FN_ADD:  res = opa + opb;
      FN_SUB:  res = opa - opb;
      default: res = opa * opb;   // low half of the product
    endcase
  end

endmodule

// File: rtl/mc_cpu_ctrl.sv
module mc_cpu_ctrl
  import mc_cpu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] op,
  output state_e     state,
  output logic       step_last
);

  state_e            state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CNT_W-1:0]  cost;

  // Cycle cost of the current micro-step
  always_comb begin
    unique case (state_q)
      S_FMEM, S_XMEM: cost = CNT_W'(CYC_MEM);
      S_DEC:          cost = CNT_W'(CYC_DEC);
      S_XALU:         cost = (op == OP_MUL_RR) ? CNT_W'(CYC_MUL) : CNT_W'(CYC_ADD);
      default:        cost = CNT_W'(CYC_XFER);
    endcase
  end

  assign step_last = (cnt_q == cost - CNT_W'(1));

  // Next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = step_last ? '0 : cnt_q + CNT_W'(1);
    if (step_last) begin
      unique case (state_q)
        S_FADDR: state_d = S_FMEM;
        S_FMEM:  state_d = S_FIR;
        S_FIR:   state_d = S_DEC;
        S_DEC: begin
          unique case (op)
            OP_HALT:                       state_d = S_HALT;
            OP_MOV_RR:                     state_d = S_XREG;
            OP_ADD_RR, OP_SUB_RR, OP_MUL_RR: state_d = S_XALU;
            OP_LOAD, OP_STORE,
            OP_ADD_RM, OP_SUB_RM:          state_d = S_XADDR;
            default:                       state_d = S_FADDR;
          endcase
        end
        S_XADDR: state_d = S_XMEM;
        S_XMEM: begin
          if (op == OP_STORE)     state_d = S_FADDR;
          else if (op == OP_LOAD) state_d = S_XREG;
          else                    state_d = S_XALU;
        end
        S_XREG:  state_d = S_FADDR;
        S_XALU:  state_d = S_FADDR;
        default: state_d = S_HALT;
      endcase
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_FADDR;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state = state_q;

endmodule

// File: rtl/mc_cpu.sv
module mc_cpu
  import mc_cpu_pkg::*;
#(
  parameter int DW   = 16,
  parameter int AW   = 8,
  parameter int NREG = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic          halted
);

  localparam int RW     = $clog2(NREG);
  localparam int OP_TOP = DW - 1;
  localparam int RI_TOP = DW - 5;
  localparam int RJ_TOP = RI_TOP - RW;

  state_e        state;
  logic          step_last;
  logic [DW-1:0] ir_q;
  logic [AW-1:0] pc_q, mar_q, mar_d;
  logic [DW-1:0] mdr_q, mdr_d;
  logic          pc_en, mar_en, mdr_en, ir_en;
  logic [3:0]    op;
  logic [RW-1:0] ri, rj;
  logic [DW-1:0] rd_a, rd_b;
  logic          rf_we;
  logic [DW-1:0] rf_wd;
  logic          mem_form;
  alu_fn_e       alu_fn;
  logic [DW-1:0] alu_b, alu_y;

  assign op = ir_q[OP_TOP -: 4];
  assign ri = ir_q[RI_TOP -: RW];
  assign rj = ir_q[RJ_TOP -: RW];

  mc_cpu_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .op        (op),
    .state     (state),
    .step_last (step_last)
  );

  mc_cpu_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (rf_we),
    .wr_sel    (ri),
    .wr_data   (rf_wd),
    .rd_sel_a  (ri),
    .rd_sel_b  (rj),
    .rd_data_a (rd_a),
    .rd_data_b (rd_b)
  );

  assign mem_form = (op == OP_ADD_RM) || (op == OP_SUB_RM);
  assign alu_b    = mem_form ? mdr_q : rd_b;

  always_comb begin
    unique case (op)
      OP_ADD_RR, OP_ADD_RM: alu_fn = FN_ADD;
      OP_SUB_RR, OP_SUB_RM: alu_fn = FN_SUB;
      default:              alu_fn = FN_MUL;
    endcase
  end

  mc_cpu_alu #(.DW(DW)) u_alu (
    .fn  (alu_fn),
    .opa (rd_a),
    .opb (alu_b),
    .res (alu_y)
  );

  // Datapath enables and next values
  always_comb begin
    pc_en  = 1'b0;
    mar_en = 1'b0;
    mar_d  = pc_q;
    mdr_en = 1'b0;
    mdr_d  = mem_rdata;
    ir_en  = 1'b0;
    rf_we  = 1'b0;
    rf_wd  = alu_y;
    unique case (state)
      S_FADDR: mar_en = 1'b1;
      S_FMEM: begin
        mdr_en = step_last;
        pc_en  = step_last;
      end
      S_FIR: ir_en = 1'b1;
      S_XADDR: begin
        mar_en = 1'b1;
        mar_d  = ir_q[AW-1:0] & ~AW'(1);
        if (op == OP_STORE) begin
          mdr_en = 1'b1;
          mdr_d  = rd_a;
        end
      end
      S_XMEM: mdr_en = step_last && (op != OP_STORE);
      S_XREG: begin
        rf_we = 1'b1;
        rf_wd = (op == OP_MOV_RR) ? rd_b : mdr_q;
      end
      S_XALU: rf_we = step_last;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      mar_q <= '0;
      mdr_q <= '0;
      ir_q  <= '0;
    end else begin
      if (pc_en)  pc_q  <= pc_q + AW'(2);
      if (mar_en) mar_q <= mar_d;
      if (mdr_en) mdr_q <= mdr_d;
      if (ir_en)  ir_q  <= mdr_q;
    end
  end

  assign mem_addr  = mar_q;
  assign mem_wdata = mdr_q;
  assign mem_req   = (state == S_FMEM) || (state == S_XMEM);
  assign mem_we    = (state == S_XMEM) && (op == OP_STORE);
  assign halted    = (state == S_HALT);

endmodule

// File: rtl/mc_cpu_sva.sv
module mc_cpu_sva
  import mc_cpu_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_req,
  input logic          mem_we,
  input logic          halted
);

  logic [CNT_W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run_q <= '0;
    else if (mem_req) run_q <= run_q + CNT_W'(1);
    else              run_q <= '0;
  end

  p_halt_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  p_quiet_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_req);

  p_we_in_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_req);

  p_store_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_req)) |-> ($past(mem_we) && $stable(mem_wdata)));

  p_addr_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && $past(mem_req)) |-> $stable(mem_addr));

  p_even_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[0] == 1'b0));

  p_win_short_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (run_q < CNT_W'(CYC_MEM)));

  p_win_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_req) |-> (run_q == CNT_W'(CYC_MEM)));

endmodule

bind mc_cpu mc_cpu_sva #(.DW(DW), .AW(AW)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .halted    (halted)
);

// File: tb/sim_mc_cpu.sv
`timescale 1ns/1ps
module sim_mc_cpu;

  localparam int L_ST = 25, L_LD = 26, L_MV = 15, L_AR = 16, L_MU = 19,
                 L_AM = 27, L_HT = 14;
  localparam int XADR = 8'h80, YADR = 8'h82, SENT = 16'hDEAD;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic        mem_req, mem_we, halted;
  logic [15:0] mem [128];
  logic [15:0] xv, yv;
  int          errors = 0, checks = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  mc_cpu u0 (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_req(mem_req), .mem_we(mem_we), .halted(halted)
  );

  function automatic logic [15:0] enc(int op, int ri, int rj, int x);
    return {4'(op), 2'(ri), 2'(rj), 8'(x)};
  endfunction

  function automatic logic [15:0] init_word(int k);
    case (k)
      0:  return enc(3, 3, 0, 8'h9A);   // store R3 (reset value)
      1:  return enc(2, 0, 0, XADR);    // load R0
      2:  return enc(2, 1, 0, YADR);    // load R1
      3:  return enc(1, 2, 0, 0);       // R2 <- R0
      4:  return enc(4, 2, 1, 0);       // R2 += R1
      5:  return enc(1, 3, 0, 0);       // R3 <- R0
      6:  return enc(6, 3, 1, 0);       // R3 -= R1
      7:  return enc(8, 2, 3, 0);       // R2 *= R3
      8:  return enc(3, 2, 0, 8'h90);
      9:  return enc(5, 0, 0, YADR);    // R0 += M[Y]
      10: return enc(3, 0, 0, 8'h92);
      11: return enc(7, 1, 0, XADR);    // R1 -= M[X]
      12: return enc(3, 1, 0, 8'h94);
      13: return enc(3, 3, 0, 8'h96);
      14: return enc(0, 0, 0, 0);       // halt
      15: return enc(3, 0, 0, 8'h98);   // must never run
      64: return xv;
      65: return yv;
      default: return 16'(SENT);
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 128; k++) mem[k] <= init_word(k);
    end else if (mem_we) begin
      mem[mem_addr[7:1]] <= mem_wdata;
    end
  end
  assign mem_rdata = mem[mem_addr[7:1]];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s x=%h y=%h actual=%h expected=%h", req, xv, yv, act, exp);
    end
  endtask

  task automatic run_one(logic [15:0] x, logic [15:0] y);
    int cnt, wecnt, ri;
    int starts [5];
    logic pw;
    xv = x; yv = y;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset outputs", {halted, mem_req, mem_we}, 3'b000);
    // store window openings: instruction offset + fetch/decode/address set-up
    starts[0] = 0;
    starts[1] = L_ST + 2*L_LD + 2*L_MV + 2*L_AR + L_MU;
    starts[2] = starts[1] + L_ST + L_AM;
    starts[3] = starts[2] + L_ST + L_AM;
    starts[4] = starts[3] + L_ST;
    rst_n = 1'b1;
    cnt = 0; wecnt = 0; ri = 0; pw = 1'b0;
    while (1) begin
      @(posedge clk); cnt++;
      @(negedge clk);
      if (mem_we) wecnt++;
      if (mem_we && !pw) begin
        if (ri < 5) chk("R3 R4 store start cycle", cnt, starts[ri] + 15);
        else chk("R8 extra store", ri, 5);
        ri++;
      end
      pw = mem_we;
      if (halted) break;
      if (cnt > 2000) begin chk("watchdog", 0, 1); break; end
    end
    chk("R8 halt cycle", cnt, starts[4] + L_ST + L_HT);
    chk("R7 write cycles", wecnt, 50);
    repeat (30) begin
      @(negedge clk);
      if (mem_req || !halted) chk("R8 quiet after halt", {halted, mem_req}, 2'b10);
    end
    chk("R1 reset register zero", mem[8'h9A >> 1], 0);
    chk("R5 R6 multiply low half", mem[8'h90 >> 1], 16'((x + y) * (x - y)));
    chk("R5 R6 add memory form", mem[8'h92 >> 1], 16'(x + y));
    chk("R6 subtract memory form", mem[8'h94 >> 1], 16'(y - x));
    chk("R5 R6 subtract register form", mem[8'h96 >> 1], 16'(x - y));
    chk("R8 halt blocks later store", mem[8'h98 >> 1], SENT);
    chk("R2 R9 operands untouched", {mem[64], mem[65]}, {x, y});
  endtask

  initial begin
    logic [15:0] vals [7];
    vals = '{16'h0000, 16'h0001, 16'h0002, 16'h1234, 16'h7FFF, 16'h8000, 16'hFFFF};
    for (int a = 0; a < 7; a++)
      for (int b = 0; b < 7; b++)
        run_one(vals[a], vals[b]);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule